// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a clocked static memory with a built-in burst address generator. It holds 1K words of 36 bits by default, arranged as four 9-bit byte lanes. Every address, control and write-data input is captured on the rising clock edge. Either of two start strobes loads a new base address. Later cycles then step a 2-bit counter that walks the four words of an aligned group, in linear or interleaved order. Writes can touch any subset of the byte lanes. A global-write control stores all lanes at once.

Read data comes out through a two-stage pipeline onto a single bidirectional data bus. The block releases that bus whenever it has no read data to present. Three chip selects gate the start strobes, so several devices can share the bus. Deselection takes effect in one cycle.

Top module: `burst_sram`

## Requirements
- R1: Read data is driven on `data_io` starting after the second rising edge that follows the cycle in which the read's address and controls were presented. It stays valid until the next rising edge.
- R2: A low `start_cpu_n` with the device selected begins a read burst at `addr_i`. All write controls are ignored in that cycle.
- R3: A low `start_ctl_n` with the device selected begins a burst at `addr_i`. That first access is a write when any lane write is requested, and a read otherwise.
- R4: When both start strobes are low and the device is selected, `start_cpu_n` takes precedence and the access is a read. Memory is left unchanged.
- R5: The device is selected only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. A low `start_ctl_n` while not selected ends the burst, makes no access, and leaves the bus released. A low `start_cpu_n` while not selected is ignored, and the cycle behaves as if neither strobe were low.
- R6: In a cycle with no start strobe during a live burst, a low `step_n` advances the burst counter by one. A high `step_n` repeats the current address. Either way the cycle reads, or writes when lane writes are requested.
- R7: With `burst_ilv` low, the two low address bits of burst access k are (start + k) mod 4. The upper bits never change within a burst, and a fifth step returns to the start word.
- R8: With `burst_ilv` high, the two low address bits of burst access k are start XOR k.
- R9: A low `wr_all_n` writes all four lanes, whatever `wr_lane_en_n` and `wr_lane_n` are. Lane i is `data_io[9i+8:9i]`.
- R10: With `wr_all_n` high, lane i is written only when `wr_lane_en_n` is low and `wr_lane_n[i]` is low. With `wr_lane_en_n` high, no lane is written and the cycle is a read.
- R11: A high `out_en_n` releases the bus at once without disturbing the pipeline. The bus is also released in output slots that belong to writes or idle cycles.
- R12: After reset the bus is released and no burst is live. A cycle with no start strobe makes no access until a new burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word address loaded at burst start |
| start_cpu_n | input | 1 | Read-only burst start strobe, active low, has priority |
| start_ctl_n | input | 1 | Read-or-write burst start strobe, active low; ends the burst when not selected |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of every lane, active low |
| wr_lane_en_n | input | 1 | Enables the per-lane write strobes, active low |
| wr_lane_n | input | LANES | Per-lane write strobes, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output driver enable, active low, not registered |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| data_io | inout | LANES*LANE_W | Shared write-data and read-data bus |

## Verification
The failures that matter here are a wrong burst counter or base register, a wrong live flag, and a wrong lane mask. A bad counter or base sends an access to a neighbouring word in the same group. That shows up as a wrong word on the bus two edges after the faulty step, or, for a write, on a later read of either word. A wrong live flag makes the bus carry data after a deselect, when it should stay released, and this is visible in the same two-edge window. A wrong lane mask shows up only when the word is read back. The bench therefore reads back every pattern it writes, and it compares the bus on every cycle against a behavioural model.

// File: rtl/burst_sram_pkg.sv
// Shared constants and types for the burst SRAM.
// Assumes a burst always covers four words (2-bit counter).
package burst_sram_pkg;
    localparam int unsigned BURST_CNT_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/burst_sram_addrgen.sv
// Burst address generator: holds the base address of the live burst and a
// 2-bit step counter, and forms the word address of the current access.
// Assumes ADDR_W > BURST_CNT_W; start_i has priority over step_i.
module burst_sram_addrgen
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    input  logic              order_ilv_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    output logic [ADDR_W-1:0] acc_addr_o
);
    localparam int unsigned CW = BURST_CNT_W;

    logic [ADDR_W-1:0] base_q, base_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [CW-1:0]     low_bits;

    // Next base and counter: load on start, count on step, else hold.
    always_comb begin
        base_n = start_i ? load_addr_i : base_q;
        if (start_i) begin
            cnt_n = '0;
        end else if (step_i) begin
            cnt_n = cnt_q + CW'(1);
        end else begin
            cnt_n = cnt_q;
        end
    end

    // Low address bits in the selected order; upper bits come from the base.
    always_comb begin
        if (order_ilv_i) begin
            low_bits = base_n[CW-1:0] ^ cnt_n;
        end else begin
            low_bits = base_n[CW-1:0] + cnt_n;
        end
        acc_addr_o = {base_n[ADDR_W-1:CW], low_bits};
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_n;
            cnt_q  <= cnt_n;
        end
    end

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !step_i) |=> ($stable(cnt_q) && $stable(base_q))); // R6

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i) |=> (cnt_q == $past(cnt_q) + CW'(1) && $stable(base_q))); // R6
endmodule

// File: rtl/burst_sram_wdec.sv
// Write-enable decode: turns the global-write, lane-enable and per-lane
// strobes (all active low) into an active-high lane write mask.
// Global write overrides every other write control.
module burst_sram_wdec #(
    parameter int unsigned LANES = 4
) (
    input  logic             wr_all_n_i,
    input  logic             wr_lane_en_n_i,
    input  logic [LANES-1:0] wr_lane_n_i,
    output logic [LANES-1:0] lane_we_o
);
    // Per-lane decode with the global override.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_we_o[g] = !wr_all_n_i || (!wr_lane_en_n_i && !wr_lane_n_i[g]);
        end
    end
endmodule

// File: rtl/burst_sram_array.sv
// Storage and output stage: one memory per byte lane. A registered access
// is performed on the next edge; a read loads the output register and
// raises rd_vld_o for one cycle. Memory contents are not reset.
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  acc_kind_e               acc_kind_i,
    input  logic [ADDR_W-1:0]       acc_addr_i,
    input  logic [LANES-1:0]        acc_mask_i,
    input  logic [LANES*LANE_W-1:0] acc_data_i,
    output logic [LANES*LANE_W-1:0] rd_data_o,
    output logic                    rd_vld_o
);
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned DATA_W = LANES * LANE_W;

    wire [DATA_W-1:0] lane_bus;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane write when the access is a write and this lane is enabled.
        always_ff @(posedge clk) begin
            if (acc_kind_i == ACC_WRITE && acc_mask_i[g]) begin
                mem_q[acc_addr_i] <= acc_data_i[g*LANE_W +: LANE_W];
            end
        end

        // Lane read into the output register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else if (acc_kind_i == ACC_READ) begin
                rd_q <= mem_q[acc_addr_i];
            end
        end

        assign lane_bus[g*LANE_W +: LANE_W] = rd_q;
    end

    assign rd_data_o = lane_bus;

    // Output-valid flag: high for exactly the cycle after a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o <= 1'b0;
        end else begin
            rd_vld_o <= (acc_kind_i == ACC_READ);
        end
    end
endmodule

// File: rtl/burst_sram.sv
// Synchronous burst SRAM top: chip-select and strobe decode, burst
// liveness, input registers for the access, and the bus driver.
// Assumes the bus master drives data_io only while out_en_n is high or
// no read data is due.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    start_cpu_n,
    input  logic                    start_ctl_n,
    input  logic                    step_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    out_en_n,
    input  logic                    burst_ilv,
    inout  wire  [LANES*LANE_W-1:0] data_io
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic              chip_on, cpu_go, ctl_go, begin_burst, drop, carry_on, step;
    logic              live_q;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    acc_kind_e         kind_n, kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;

    // Strobe and select decode; the read-only strobe wins over the other.
    always_comb begin
        chip_on     = !sel_a_n && sel_b && !sel_c_n;
        cpu_go      = !start_cpu_n && chip_on;
        ctl_go      = !cpu_go && !start_ctl_n;
        begin_burst = cpu_go || (ctl_go && chip_on);
        drop        = ctl_go && !chip_on;
        carry_on    = !cpu_go && start_ctl_n && live_q;
        step        = carry_on && !step_n;
    end

    burst_sram_wdec #(.LANES(LANES)) wdec_i (
        .wr_all_n_i     (wr_all_n),
        .wr_lane_en_n_i (wr_lane_en_n),
        .wr_lane_n_i    (wr_lane_n),
        .lane_we_o      (lane_we)
    );

    burst_sram_addrgen #(.ADDR_W(ADDR_W)) addrgen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (begin_burst),
        .step_i      (step),
        .order_ilv_i (burst_ilv),
        .load_addr_i (addr_i),
        .acc_addr_o  (acc_addr)
    );

    // Kind of access this cycle: a forced read, a read/write, or nothing.
    always_comb begin
        if (cpu_go) begin
            kind_n = ACC_READ;
        end else if (begin_burst || carry_on) begin
            kind_n = (|lane_we) ? ACC_WRITE : ACC_READ;
        end else begin
            kind_n = ACC_IDLE;
        end
    end

    // Burst liveness: set by a start, cleared by a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else if (begin_burst) begin
            live_q <= 1'b1;
        end else if (drop) begin
            live_q <= 1'b0;
        end
    end

    // Input registers holding the access for the array stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ACC_IDLE;
            addr_q <= '0;
            mask_q <= '0;
            data_q <= '0;
        end else begin
            kind_q <= kind_n;
            addr_q <= acc_addr;
            mask_q <= cpu_go ? '0 : lane_we;
            data_q <= data_io;
        end
    end

    burst_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) array_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_kind_i (kind_q),
        .acc_addr_i (addr_q),
        .acc_mask_i (mask_q),
        .acc_data_i (data_q),
        .rd_data_o  (rd_data),
        .rd_vld_o   (rd_vld)
    );

    // Bus driver: gated by the output enable, released otherwise.
    assign data_io = (rd_vld && !out_en_n) ? rd_data : {DATA_W{1'bz}};

    AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_go |=> (kind_q == ACC_READ)); // R2

    AST_DROP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (kind_q == ACC_IDLE && !live_q)); // R5

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_n && ctl_go && chip_on) |=> (kind_q == ACC_WRITE && mask_q == '1)); // R9

    AST_DRIVE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(kind_q == ACC_READ)); // R1

    AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        carry_on |=> (addr_q[ADDR_W-1:BURST_CNT_W] == $past(addr_q[ADDR_W-1:BURST_CNT_W]))); // R7
endmodule

// File: tb/burst_sram_tb_top.sv
// Bench: a behavioural reference model steps on every rising edge, and
// the bus is compared with it at every falling edge.
module burst_sram_tb_top;
    localparam int AW = 10;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          scpu = 1'b1, sctl = 1'b1, stp = 1'b1;
    logic          wall = 1'b1, wlen = 1'b1;
    logic [3:0]    wl = 4'hf;
    logic          ca = 1'b0, cb = 1'b1, cc = 1'b0;
    logic          oe = 1'b0, ilv = 1'b0;
    logic          tb_drv = 1'b0;
    logic [DW-1:0] tb_d = '0;
    wire  [DW-1:0] bus_w;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    logic [DW-1:0] mm [1024];
    bit            m_live;
    logic [AW-1:0] m_base;
    int            m_cnt;
    int            p_kind;
    logic [AW-1:0] p_addr;
    logic [3:0]    p_mask;
    logic [DW-1:0] p_data;
    bit            o_drv;
    logic [DW-1:0] o_dat;

    always #2 clk = ~clk;

    assign bus_w = tb_drv ? tb_d : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (bus_w[i]);
    end

    burst_sram dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr),
        .start_cpu_n  (scpu),
        .start_ctl_n  (sctl),
        .step_n       (stp),
        .wr_all_n     (wall),
        .wr_lane_en_n (wlen),
        .wr_lane_n    (wl),
        .sel_a_n      (ca),
        .sel_b        (cb),
        .sel_c_n      (cc),
        .out_en_n     (oe),
        .burst_ilv    (ilv),
        .data_io      (bus_w)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bus=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit         on, cpu, ctl;
        logic [3:0] mask;
        int         lo;
        // second stage: perform the access registered last edge
        o_drv = 1'b0;
        if (p_kind == 1) begin
            o_drv = 1'b1;
            o_dat = mm[p_addr];
        end else if (p_kind == 2) begin
            for (int i = 0; i < 4; i++)
                if (p_mask[i]) mm[p_addr][i*9 +: 9] = p_data[i*9 +: 9];
        end
        // first stage: decide this cycle's access
        on   = !ca && cb && !cc;
        cpu  = !scpu && on;
        ctl  = !cpu && !sctl;
        mask = !wall ? 4'hf : (!wlen ? ~wl : 4'h0);
        p_kind = 0;
        if (cpu) begin
            m_live = 1; m_base = addr; m_cnt = 0; p_kind = 1; mask = 4'h0;
        end else if (ctl && on) begin
            m_live = 1; m_base = addr; m_cnt = 0; p_kind = (mask != 0) ? 2 : 1;
        end else if (ctl) begin
            m_live = 0;
        end else if (m_live) begin
            if (!stp) m_cnt = (m_cnt + 1) % 4;
            p_kind = (mask != 0) ? 2 : 1;
        end
        lo     = ilv ? (int'(m_base[1:0]) ^ m_cnt) : ((int'(m_base[1:0]) + m_cnt) % 4);
        p_addr = {m_base[AW-1:2], 2'(lo)};
        p_mask = mask;
        p_data = bus_w;
    endtask

    // One cycle: inputs are already set at a falling edge.
    task automatic tick(input string tag);
        tb_drv = (!wall || (!wlen && wl != 4'hf));
        if (tb_drv) oe = 1'b1;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!tb_drv)
            check(tag, bus_w, (o_drv && !oe) ? o_dat : {DW{1'b1}});
    endtask

    task automatic quiet();
        scpu = 1; sctl = 1; stp = 1; wall = 1; wlen = 1; wl = 4'hf;
        ca = 0; cb = 1; cc = 0; oe = 0; tb_drv = 0;
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        logic [8:0] v;
        v = 9'(a) ^ 9'h055;
        return {v, ~v, v ^ 9'h0f0, v} & ~36'h1;
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run=%0d expected=done", n_tests);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_live = 0; p_kind = 0; o_drv = 0; o_dat = '0; m_base = '0; m_cnt = 0;
        p_addr = '0; p_mask = '0; p_data = '0;
        for (int i = 0; i < 1024; i++) mm[i] = '0;
        quiet();
        repeat (3) @(negedge clk);
        check("R12", bus_w, {DW{1'b1}});
        rst_n = 1'b1;
        stp = 0; tick("R12"); tick("R12"); tick("R12");
        quiet();

        // fill words 0..255 with linear write bursts started by the ctl strobe
        for (int b = 0; b < 64; b++) begin
            quiet(); sctl = 0; addr = AW'(b*4); wall = 0; tb_d = pat(b*4);
            tick("R3");
            for (int j = 1; j < 4; j++) begin
                quiet(); stp = 0; wall = 0; tb_d = pat(b*4 + j);
                tick("R6");
            end
        end
        quiet(); tick("R1"); tick("R1");

        // linear read burst from a mid-group start, with wrap
        scpu = 0; addr = 10'h041; tick("R2");
        for (int j = 0; j < 4; j++) begin quiet(); stp = 0; tick("R7"); end
        quiet(); tick("R1"); tick("R1");

        // interleaved read burst
        ilv = 1; scpu = 0; addr = 10'h042; tick("R8");
        for (int j = 0; j < 3; j++) begin quiet(); stp = 0; tick("R8"); end
        quiet(); tick("R8"); tick("R8"); ilv = 0;

        // hold without step, then step
        scpu = 0; addr = 10'h010; tick("R6");
        quiet(); tick("R6"); tick("R6");
        stp = 0; tick("R6"); quiet(); tick("R6"); tick("R6");

        // partial lane write, then a no-write read cycle, then read back
        sctl = 0; addr = 10'h080; wlen = 0; wl = 4'b1010; tb_d = 36'h1_2345_6788;
        tick("R10");
        quiet(); sctl = 0; addr = 10'h081; wlen = 1; wl = 4'b0000; tick("R10");
        quiet(); tick("R10");
        scpu = 0; addr = 10'h080; tick("R10");
        quiet(); tick("R10"); tick("R10");

        // global write overrides disabled lane controls
        sctl = 0; addr = 10'h090; wall = 0; wlen = 1; wl = 4'hf; tb_d = 36'h9_8765_4320;
        tick("R9");
        quiet(); tick("R9");
        scpu = 0; addr = 10'h090; tick("R9");
        quiet(); tick("R9"); tick("R9");

        // both strobes: read wins, no write happens
        scpu = 0; sctl = 0; addr = 10'h095; wall = 0; tb_d = 36'h0_0000_abc0;
        tick("R4");
        quiet(); tick("R4");
        scpu = 0; addr = 10'h095; tick("R4");
        quiet(); tick("R4"); tick("R4");

        // deselect ends the burst; cpu strobe while deselected is ignored
        scpu = 0; addr = 10'h020; tick("R5");
        quiet(); sctl = 0; cb = 0; tick("R5");
        quiet(); stp = 0; tick("R5"); tick("R5");
        quiet(); scpu = 0; ca = 1; tick("R5");
        quiet(); tick("R5"); tick("R5");
        scpu = 0; addr = 10'h030; tick("R5");
        quiet(); scpu = 0; cc = 1; stp = 0; tick("R5");
        quiet(); tick("R5"); tick("R5");

        // output enable releases the bus without shifting the pipeline
        scpu = 0; addr = 10'h050; oe = 1; tick("R11");
        quiet(); stp = 0; oe = 1; tick("R11");
        quiet(); stp = 0; tick("R11");
        quiet(); oe = 1; tick("R11");
        quiet(); tick("R11"); tick("R11");

        // mixed traffic over the filled region
        for (int k = 0; k < 600; k++) begin
            quiet();
            addr = AW'($urandom_range(0, 255));
            scpu = ($urandom_range(0, 5) != 0);
            sctl = ($urandom_range(0, 4) != 0);
            stp  = $urandom_range(0, 1) == 1;
            wall = ($urandom_range(0, 5) != 0);
            wlen = $urandom_range(0, 1) == 1;
            wl   = 4'($urandom_range(0, 15));
            ca   = ($urandom_range(0, 9) == 0);
            cb   = ($urandom_range(0, 9) != 0);
            cc   = ($urandom_range(0, 9) == 0);
            oe   = ($urandom_range(0, 7) == 0);
            ilv  = $urandom_range(0, 1) == 1;
            tb_d = {4'($urandom_range(0, 15)), 32'($urandom)} & ~36'h1;
            tick("R1");
        end
        quiet(); tick("R1"); tick("R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule